// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every received frame, whether its 48-bit destination address passes. It holds a bank of sixteen programmable exact-match address entries, each gated by its own valid flag, and a 4096-bit multicast hash table. A frame whose address equals any valid entry is accepted as an exact hit, and the hash table is not consulted for it. Otherwise a 12-bit hash is cut from the top two address bytes, at a bit offset chosen by a 2-bit mode, and the selected table bit decides the frame.

Software programs the entries, the mode and the table through a simple 32-bit register-write port. The frame path offers one destination address per strobe. One clock later the block presents a result valid flag, the accept decision and an exact-versus-hash indication. It also gives a one-cycle pulse whenever a frame is accepted by the hash table, for a multicast statistics counter.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset every entry is invalid, the mode is 0 and every table bit is 0, so every lookup is rejected.
- R2: `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high; `res_accept`, `res_exact` and `mcast_hit` are 0 whenever `res_valid` is 0.
- R3: Address byte k is `lk_dst[8k+7:8k]`. Config address 2k writes entry k's low word (bytes 0..3, byte 0 in bits 7:0). Config address 2k+1 writes its high word: byte 4 in bits 7:0, byte 5 in bits 15:8, valid flag in bit 31. Address 0x20 writes the mode in bits 1:0. Addresses 0x80..0xFF write table word `cfg_addr[6:0]`.
- R4: An entry whose valid flag is 0 never matches, even when its stored address equals the lookup address.
- R5: A lookup equal to any valid entry gives `res_accept`=1 and `res_exact`=1, with no `mcast_hit`, whatever the table holds.
- R6: The hash is the low 12 bits of `{byte5, byte4}` shifted right by 4, 3, 2 or 0 for mode 0, 1, 2 or 3.
- R7: Without an exact hit, hash bits 11:5 pick a table word and hash bits 4:0 a bit in it. If that bit is 1 the frame is accepted with `res_exact`=0.
- R8: A hash-based accept raises `mcast_hit` for exactly the one result cycle.
- R9: An entry, mode or table write in the same cycle as a lookup does not affect that lookup; it applies from the next one.
- R10: Without an exact hit and with the selected table bit 0, the frame is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_dst | input | 48 | Destination address to filter |
| res_valid | output | 1 | Result present (one cycle after strobe) |
| res_accept | output | 1 | Frame accepted |
| res_exact | output | 1 | Accept came from an exact entry |
| mcast_hit | output | 1 | Pulse on hash-based accept |

## Verification
The hardest situation to reach from the ports is a configuration write that lands in the very cycle of a lookup it would change. The bench drives a write and a lookup on the same edge and expects the old decision, then repeats the lookup and expects the new one. This is done for an entry's valid flag, a table word and the mode. A second hard case is an address that both matches a valid entry and hashes onto a set table bit. Directed stimulus builds it by setting the hash bit of a programmed address, and the bench then checks that the exact hit wins and no multicast pulse appears.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  // Destination address width and hash geometry fixed by the filter's function.
  parameter int MAC_W   = 48;
  parameter int HASH_W  = 12;
  parameter int HSRC_W  = 16;

  function automatic logic [2:0] mode_shift(input logic [1:0] mode);
    case (mode)
      2'd0:    return 3'd4;
      2'd1:    return 3'd3;
      2'd2:    return 3'd2;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rxaf_cfg_decode.sv
module rxaf_cfg_decode #(
  parameter int NUM_ENT = 16,
  parameter int CFG_AW  = 8,
  parameter int IDX_W   = 7
) (
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  output logic [NUM_ENT-1:0] ent_we_lo,
  output logic [NUM_ENT-1:0] ent_we_hi,
  output logic              mode_we,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_waddr
);
  localparam int ENT_SEL_W = $clog2(NUM_ENT) + 1;
  localparam logic [CFG_AW-1:0] MODE_ADDR = CFG_AW'(2 * NUM_ENT);

  logic in_tbl, in_ent;

  assign in_tbl    = cfg_addr[CFG_AW-1];
  assign in_ent    = !in_tbl && (cfg_addr[CFG_AW-2:ENT_SEL_W] == '0);
  assign tbl_we    = cfg_we && in_tbl;
  assign tbl_waddr = cfg_addr[IDX_W-1:0];
  assign mode_we   = cfg_we && (cfg_addr == MODE_ADDR);

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_sel
    assign ent_we_lo[k] = cfg_we && in_ent && (cfg_addr[ENT_SEL_W-1:0] == ENT_SEL_W'(2 * k));
    assign ent_we_hi[k] = cfg_we && in_ent && (cfg_addr[ENT_SEL_W-1:0] == ENT_SEL_W'(2 * k + 1));
  end
endmodule

// File: rtl/rxaf_exact_bank.sv
module rxaf_exact_bank #(
  parameter int NUM_ENT = 16,
  parameter int MAC_W   = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ENT-1:0] we_lo,
  input  logic [NUM_ENT-1:0] we_hi,
  input  logic [31:0]        wdata,
  input  logic               lk_valid,
  input  logic [MAC_W-1:0]   lk_dst,
  output logic               hit_q
);
  localparam int HI_W  = MAC_W - 32;
  localparam int VBIT  = 31;

  logic [31:0]        lo_q  [NUM_ENT];
  logic [HI_W-1:0]    hi_q  [NUM_ENT];
  logic [NUM_ENT-1:0] vld_q;
  logic [NUM_ENT-1:0] match;
  logic               unused_wbits;

  assign unused_wbits = ^wdata[VBIT-1:HI_W];

  for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[k]  <= '0;
        hi_q[k]  <= '0;
        vld_q[k] <= 1'b0;
      end else begin
        if (we_lo[k]) lo_q[k] <= wdata;
        if (we_hi[k]) begin
          hi_q[k]  <= wdata[HI_W-1:0];
          vld_q[k] <= wdata[VBIT];
        end
      end
    end
    // Stored layout is little-endian, identical bit-for-bit to lk_dst.
    assign match[k] = vld_q[k] && ({hi_q[k], lo_q[k]} == lk_dst);
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= lk_valid && (|match);
  end

  // R4: an exact hit needs at least one entry that was valid at lookup time
  assert_hit_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(|vld_q));
endmodule

// File: rtl/rxaf_hash_index.sv
module rxaf_hash_index #(
  parameter int HSRC_W = 16,
  parameter int HASH_W = 12,
  parameter int IDX_W  = 7,
  parameter int BIT_W  = 5
) (
  input  logic [HSRC_W-1:0] hsrc,
  input  logic [1:0]        mode,
  output logic [IDX_W-1:0]  word_idx,
  output logic [BIT_W-1:0]  bit_idx
);
  logic [HSRC_W-1:0] shifted;
  logic [HASH_W-1:0] hash;
  logic              unused_shift_hi;

  assign shifted         = hsrc >> rxaf_pkg::mode_shift(mode);
  assign hash            = shifted[HASH_W-1:0];
  assign unused_shift_hi = ^shifted[HSRC_W-1:HASH_W];
  assign word_idx        = hash[HASH_W-1:BIT_W];
  assign bit_idx         = hash[BIT_W-1:0];
endmodule

// File: rtl/rxaf_hash_table.sv
module rxaf_hash_table #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 7,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [BIT_W-1:0]  rd_bit,
  output logic              bit_out
);
  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] rd_word_q;
  logic [WORDS-1:0]  written_q;
  logic              written_rd_q;
  logic [BIT_W-1:0]  bit_q;

  // Plain RAM: read-before-write so a same-cycle write is not seen.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (rd_en) rd_word_q <= mem[rd_idx];
  end

  // Per-word written flags give an all-zero table after reset without a sweep.
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q    <= '0;
      written_rd_q <= 1'b0;
      bit_q        <= '0;
    end else begin
      if (we) written_q[waddr] <= 1'b1;
      if (rd_en) begin
        written_rd_q <= written_q[rd_idx];
        bit_q        <= rd_bit;
      end
    end
  end

  assign bit_out = written_rd_q && rd_word_q[bit_q];

  // R9: a table write is recorded so later lookups see it
  assert_write_recorded_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we)) |-> written_q[$past(waddr)]);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int NUM_ENT = 16,
  parameter int WORD_W  = 32,
  parameter int CFG_AW  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic                     lk_valid,
  input  logic [rxaf_pkg::MAC_W-1:0] lk_dst,
  output logic                     res_valid,
  output logic                     res_accept,
  output logic                     res_exact,
  output logic                     mcast_hit
);
  localparam int TBL_WORDS = (2 ** rxaf_pkg::HASH_W) / WORD_W;
  localparam int IDX_W     = $clog2(TBL_WORDS);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int MAC_W     = rxaf_pkg::MAC_W;
  localparam int HSRC_W    = rxaf_pkg::HSRC_W;

  logic [NUM_ENT-1:0] ent_we_lo, ent_we_hi;
  logic               mode_we, tbl_we;
  logic [IDX_W-1:0]   tbl_waddr, word_idx;
  logic [BIT_W-1:0]   bit_idx;
  logic [1:0]         mode_q;
  logic               hit_q, tbl_bit, rv_q;

  rxaf_cfg_decode #(.NUM_ENT(NUM_ENT), .CFG_AW(CFG_AW), .IDX_W(IDX_W)) u_dec (
    .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .ent_we_lo(ent_we_lo), .ent_we_hi(ent_we_hi),
    .mode_we(mode_we), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr)
  );

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 2'd0;
    else if (mode_we) mode_q <= cfg_wdata[1:0];
  end

  rxaf_exact_bank #(.NUM_ENT(NUM_ENT), .MAC_W(MAC_W)) u_bank (
    .clk(clk), .rst(rst), .we_lo(ent_we_lo), .we_hi(ent_we_hi),
    .wdata(cfg_wdata), .lk_valid(lk_valid), .lk_dst(lk_dst), .hit_q(hit_q)
  );

  rxaf_hash_index #(.HSRC_W(HSRC_W), .HASH_W(rxaf_pkg::HASH_W),
                    .IDX_W(IDX_W), .BIT_W(BIT_W)) u_idx (
    .hsrc(lk_dst[MAC_W-1:MAC_W-HSRC_W]), .mode(mode_q),
    .word_idx(word_idx), .bit_idx(bit_idx)
  );

  rxaf_hash_table #(.WORDS(TBL_WORDS), .WORD_W(WORD_W),
                    .IDX_W(IDX_W), .BIT_W(BIT_W)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_waddr),
    .wdata(cfg_wdata[WORD_W-1:0]), .rd_en(lk_valid), .rd_idx(word_idx),
    .rd_bit(bit_idx), .bit_out(tbl_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) rv_q <= 1'b0;
    else     rv_q <= lk_valid;
  end

  assign res_valid  = rv_q;
  assign res_exact  = rv_q && hit_q;
  assign res_accept = rv_q && (hit_q || tbl_bit);
  assign mcast_hit  = rv_q && !hit_q && tbl_bit;

  // R2: a result follows each strobe by exactly one cycle
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  // R1: nothing is reported in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid && !mcast_hit);
  // R8: a multicast pulse only accompanies a non-exact accept
  assert_mcast_hash_only_R8: assert property (@(posedge clk) disable iff (rst)
    mcast_hit |-> (res_accept && !res_exact));
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_dst = '0;
  logic        res_valid, res_accept, res_exact, mcast_hit;

  always #5 clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .lk_valid(lk_valid), .lk_dst(lk_dst), .res_valid(res_valid),
    .res_accept(res_accept), .res_exact(res_exact), .mcast_hit(mcast_hit)
  );

  int unsigned n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  // Bench model of programmed state
  logic [47:0] m_addr [16];
  bit          m_vld  [16];
  logic [31:0] m_tbl  [128];
  logic [1:0]  m_mode;

  task automatic check(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] hash_of(input logic [47:0] d, input logic [1:0] md);
    logic [15:0] s;
    int sh;
    sh = (md == 2'd0) ? 4 : (md == 2'd1) ? 3 : (md == 2'd2) ? 2 : 0;
    s = {d[47:40], d[39:32]} >> sh;
    return s[11:0];
  endfunction

  function automatic void model(input logic [47:0] d, output bit acc, output bit ex);
    logic [11:0] h;
    ex = 1'b0;
    for (int k = 0; k < 16; k++) if (m_vld[k] && m_addr[k] == d) ex = 1'b1;
    h = hash_of(d, m_mode);
    acc = ex || m_tbl[h[11:5]][h[4:0]];
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R3 layout: low word bytes 0..3, high word bytes 4..5 plus valid in bit 31
  task automatic set_entry(input int k, input logic [47:0] a, input bit v);
    cfg_write(8'(2 * k), a[31:0]);
    cfg_write(8'(2 * k + 1), {v, 15'b0, a[47:32]});
    m_addr[k] = a; m_vld[k] = v;
  endtask

  task automatic set_word(input int w, input logic [31:0] d);
    cfg_write(8'h80 | 8'(w), d);
    m_tbl[w] = d;
  endtask

  task automatic set_mode(input logic [1:0] md);
    cfg_write(8'h20, {30'b0, md});
    m_mode = md;
  endtask

  task automatic set_hash_bit(input logic [47:0] d);
    logic [11:0] h;
    h = hash_of(d, m_mode);
    set_word(int'(h[11:5]), m_tbl[h[11:5]] | (32'd1 << h[4:0]));
  endtask

  task automatic look_exp(input string tag, input logic [47:0] d, input bit acc, input bit ex);
    lk_valid = 1'b1; lk_dst = d;
    @(negedge clk);
    lk_valid = 1'b0;
    check({tag, " res_valid"}, res_valid, 1'b1);
    check({tag, " accept"}, res_accept, acc);
    check({tag, " exact"}, res_exact, ex);
    check({tag, " mcast"}, mcast_hit, acc && !ex);
    @(negedge clk);
    check({tag, " R2/R8 idle after result"}, res_valid | mcast_hit, 1'b0);
  endtask

  task automatic look(input string tag, input logic [47:0] d);
    bit acc, ex;
    model(d, acc, ex);
    look_exp(tag, d, acc, ex);
  endtask

  initial begin
    for (int i = 0; i < 400000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b, c;
    bit acc, ex;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++) begin m_addr[k] = '0; m_vld[k] = 1'b0; end
    for (int w = 0; w < 128; w++) m_tbl[w] = '0;
    m_mode = 2'd0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 res_valid after reset", res_valid, 1'b0);
    @(negedge clk);
    look_exp("R1 reject after reset", 48'h0, 1'b0, 1'b0);
    look_exp("R1 reject random after reset", 48'h0123_4567_89ab, 1'b0, 1'b0);

    // Exact match, first and last entries
    a = 48'h5544_3322_1100;
    set_entry(3, a, 1'b1);
    look_exp("R5 R3 exact entry 3", a, 1'b1, 1'b1);
    set_entry(0, 48'hdead_beef_0001, 1'b1);
    set_entry(15, 48'h0102_0304_0506, 1'b1);
    look_exp("R5 exact entry 0", 48'hdead_beef_0001, 1'b1, 1'b1);
    look_exp("R5 exact entry 15", 48'h0102_0304_0506, 1'b1, 1'b1);
    look_exp("R10 one bit off", 48'h0102_0304_0507, 1'b0, 1'b0);

    // Invalid entry never matches
    b = 48'haabb_ccdd_eeff;
    set_entry(5, b, 1'b0);
    look_exp("R4 invalid entry", b, 1'b0, 1'b0);

    // Hash accept under every mode
    for (int md = 0; md < 4; md++) begin
      set_mode(2'(md));
      c = {16'h9a5c + 16'(md * 16'h1111), 32'h1234_5678};
      look_exp("R10 hash bit clear", c, 1'b0, 1'b0);
      set_hash_bit(c);
      look_exp("R6 R7 R8 hash accept", c, 1'b1, 1'b0);
    end
    // Mode changes hash: bit set for mode 3 position of this addr not under mode 0
    set_mode(2'd3);
    for (int w = 0; w < 128; w++) set_word(w, 32'h0);
    c = 48'h0f0f_0000_0000;
    set_hash_bit(c);
    look_exp("R6 mode3 hit", c, 1'b1, 1'b0);
    set_mode(2'd0);
    look("R6 mode0 other bit", c);

    // Exact hit overrides a set hash bit
    set_hash_bit(a);
    look_exp("R5 exact beats hash", a, 1'b1, 1'b1);

    // Same-cycle write vs lookup: valid flag
    set_entry(7, 48'h7777_0000_1111, 1'b0);
    cfg_we = 1'b1; cfg_addr = 8'd15; cfg_wdata = {1'b1, 15'b0, 16'h7777};
    lk_valid = 1'b1; lk_dst = 48'h7777_0000_1111;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    check("R9 entry write same cycle old", res_accept, 1'b0);
    m_vld[7] = 1'b1;
    @(negedge clk);
    look_exp("R9 entry write then new", 48'h7777_0000_1111, 1'b1, 1'b1);

    // Same-cycle write vs lookup: table word
    c = 48'h3c3c_0000_2222;
    model(c, acc, ex);
    cfg_we = 1'b1; cfg_addr = 8'h80 | 8'(hash_of(c, m_mode) >> 5);
    cfg_wdata = 32'hffff_ffff;
    lk_valid = 1'b1; lk_dst = c;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    check("R9 table write same cycle old", res_accept, acc);
    m_tbl[hash_of(c, m_mode) >> 5] = 32'hffff_ffff;
    @(negedge clk);
    look_exp("R9 table write then new", c, 1'b1, 1'b0);

    // Same-cycle write vs lookup: mode
    set_mode(2'd0);
    for (int w = 0; w < 128; w++) set_word(w, 32'h0);
    c = 48'h0ff0_0000_0000;
    m_mode = 2'd3; set_hash_bit(c); m_mode = 2'd0;
    cfg_write(8'h20, 32'd0);
    cfg_we = 1'b1; cfg_addr = 8'h20; cfg_wdata = 32'd3;
    lk_valid = 1'b1; lk_dst = c;
    model(c, acc, ex);
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    check("R9 mode write same cycle old", res_accept, acc);
    m_mode = 2'd3;
    @(negedge clk);
    look_exp("R9 mode write then new", c, 1'b1, 1'b0);

    // Constrained random
    for (int it = 0; it < 600; it++) begin
      int unsigned r;
      logic [47:0] d;
      r = $urandom_range(0, 9);
      if (r == 0) set_entry(int'($urandom_range(0, 15)),
                            {$urandom(), $urandom()} & 48'hffff_ffff_ffff,
                            bit'($urandom_range(0, 1)));
      else if (r == 1) set_word(int'($urandom_range(0, 127)), $urandom());
      else if (r == 2) set_mode(2'($urandom_range(0, 3)));
      if ($urandom_range(0, 2) == 0) d = m_addr[$urandom_range(0, 15)];
      else d = {16'($urandom()), $urandom()};
      look("R5 R6 R7 R10 random", d);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule